// File: doc/BRIEF.md
# Low-Frequency Clock Source Switcher

This block produces the low-frequency clock for a chip. Two sources can feed it, an RC oscillator and a crystal oscillator. A select register names the source that the next start task will use. A one-cycle start pulse enables that source and waits for it to become ready. The block then moves the output over to it without ever stopping the clock. When the move is complete it raises a one-cycle started event. Status outputs show whether the clock is running and which source is driving it.

A stop pulse withdraws the software request. Request inputs from always-on consumers, such as a watchdog or a modem, keep a running clock alive after a stop. A system-off input forces everything off. The oscillators are modelled inside the block: each one counts a parameterised number of system cycles before it reports ready, and it toggles its level every half-period count. All logic runs on one system clock.

When the source changes while the clock is live, the output first finishes its current high phase. It is then held low until the new source is low, and only after that does it follow the new source. The low phase is stretched, but no high pulse is cut short. The old source stays enabled until the switch is complete.

Top module: `lfclk_switcher`

## Requirements
- R1: After reset the select register holds the RC source (encoding 0 = RC, 1 = crystal), so a start task with no prior write brings up the RC source. `stat_src` reads 0 out of reset.
- R2: A start task enables the selected source. Once that source is ready and the output has moved onto it, `started_evt` pulses for one cycle and `stat_running` becomes 1. The output then toggles with that source's half period.
- R3: During a live source change, the previous source keeps driving `lf_clk` and `stat_src` keeps its old value until the new source is ready and the switch is complete. After that, `stat_src` shows the new source.
- R4: Every high pulse on `lf_clk` that ends while the clock is running lasts exactly one half period of the source driving it. The active source changes only while the output is low.
- R5: A stop task while running, with no consumer request asserted, clears `stat_running` within two cycles. `lf_clk` then stays low.
- R6: While any bit of `cons_req` is asserted, a running clock keeps running and toggling after a stop task.
- R7: A stop task received while `stat_running` is 0 is ignored. The start that is in progress completes, and the clock keeps running with no consumer request.
- R8: While `sys_off` is 1, the clock, both sources and the pending start are forced off (`stat_running` 0, `lf_clk` 0). Start tasks received during that time have no effect.
- R9: `started_evt` never comes sooner than the selected source's startup count after the start task.
- R10: A start task naming the source that is already active produces a fresh `started_evt` within a few half periods, with no change of `stat_src`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_off | input | 1 | System-off mode: forces the controller and both sources off |
| src_wr | input | 1 | Write strobe for the source-select register |
| src_wdata | input | 1 | Source to select: 0 = RC, 1 = crystal |
| start_task | input | 1 | One-cycle start task |
| stop_task | input | 1 | One-cycle stop task |
| cons_req | input | N_CONS | Always-on consumer requests that hold a running clock |
| lf_clk | output | 1 | Low-frequency clock output |
| started_evt | output | 1 | One-cycle pulse when the selected source has taken over |
| stat_running | output | 1 | Status: clock running |
| stat_src | output | 1 | Status: source driving the output (0 = RC, 1 = crystal) |

## Verification
The bench gives the two sources different half periods (3 and 5 cycles) and different startup counts. This lets every high pulse on the output be tied to exactly one source, so a truncated or mixed pulse stands out.

The main function is tried in several ways:
- a cold start with the reset default;
- live changes in both directions;
- a restart of the source that is already active.

Each one separates the output following the old source from the output following the new one, and separates an early started event from a correct one. Stops are then issued with a consumer request held, with no request, and before the clock is running. These show the difference between a stop that is honoured and a stop that is overridden or ignored. Finally, system-off is asserted while the clock runs, and a start is sent during it.

// File: rtl/lfclk_pkg.sv
package lfclk_pkg;

    localparam int NUM_SRC = 2;

    typedef enum logic {
        SRC_RC = 1'b0,
        SRC_XO = 1'b1
    } lfsrc_e;

    typedef enum logic [1:0] {
        MX_IDLE     = 2'd0,
        MX_WAIT_LOW = 2'd1,
        MX_HOLD     = 2'd2
    } mux_st_e;

    typedef struct packed {
        logic   running;
        lfsrc_e src;
    } lfstat_t;

    function automatic logic [NUM_SRC-1:0] src_onehot(lfsrc_e s);
        return NUM_SRC'(1) << s;
    endfunction

endpackage

// File: rtl/lfclk_osc_model.sv
module lfclk_osc_model #(
    parameter int START_CYC = 20,
    parameter int HALF_CYC  = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic rdy,
    output logic lvl
);
    localparam int SW = $clog2(START_CYC + 1);
    localparam int HW = $clog2(HALF_CYC + 1);

    logic [SW-1:0] st_cnt;
    logic [HW-1:0] ph_cnt;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            st_cnt <= '0;
            ph_cnt <= '0;
            rdy    <= 1'b0;
            lvl    <= 1'b0;
        end else begin
            if (!rdy) begin
                if (st_cnt == SW'(START_CYC - 1)) rdy <= 1'b1;
                else                              st_cnt <= st_cnt + 1'b1;
            end
            if (ph_cnt == HW'(HALF_CYC - 1)) begin
                ph_cnt <= '0;
                lvl    <= ~lvl;
            end else begin
                ph_cnt <= ph_cnt + 1'b1;
            end
        end
    end

    // R9: readiness only ever follows a cycle of enable
    a_r9_ready_after_enable: assert property (@(posedge clk) disable iff (rst)
        $rose(rdy) |-> $past(en));

endmodule

// File: rtl/lfclk_glitchless_mux.sv
module lfclk_glitchless_mux
    import lfclk_pkg::*;
#(
    parameter int NSRC = NUM_SRC
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] lvl,
    input  logic            go,
    input  lfsrc_e          go_src,
    input  logic            halt,
    output logic            out_q,
    output lfsrc_e          act,
    output logic            done
);
    mux_st_e st;
    lfsrc_e  nxt;
    logic    live;
    logic    out_nxt;

    always_comb begin
        unique case (st)
            MX_IDLE:     out_nxt = live & lvl[act];
            MX_WAIT_LOW: out_nxt = out_q & live & lvl[act];
            default:     out_nxt = 1'b0;
        endcase
        if (halt) out_nxt = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= MX_IDLE;
            nxt   <= SRC_RC;
            act   <= SRC_RC;
            live  <= 1'b0;
            done  <= 1'b0;
            out_q <= 1'b0;
        end else begin
            done  <= 1'b0;
            out_q <= out_nxt;
            if (halt) begin
                st   <= MX_IDLE;
                live <= 1'b0;
            end else begin
                unique case (st)
                    MX_IDLE: if (go) begin
                        nxt <= go_src;
                        st  <= MX_WAIT_LOW;
                    end
                    MX_WAIT_LOW: if (!out_q) st <= MX_HOLD;
                    MX_HOLD: if (!lvl[nxt]) begin
                        act  <= nxt;
                        live <= 1'b1;
                        done <= 1'b1;
                        st   <= MX_IDLE;
                    end
                    default: st <= MX_IDLE;
                endcase
            end
        end
    end

    // R4: the selected source only moves while the output is low
    a_r4_act_moves_low: assert property (@(posedge clk) disable iff (rst)
        !$stable(act) |-> !out_q);

    // R3: the old source stays selected for the whole switch
    a_r3_act_held_while_busy: assert property (@(posedge clk) disable iff (rst)
        (st != MX_IDLE) |-> $stable(act));

endmodule

// File: rtl/lfclk_ctrl.sv
module lfclk_ctrl
    import lfclk_pkg::*;
#(
    parameter int N_CONS = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sys_off,
    input  logic               sel_wr,
    input  lfsrc_e             sel_data,
    input  logic               start_task,
    input  logic               stop_task,
    input  logic [N_CONS-1:0]  cons_req,
    input  logic [NUM_SRC-1:0] osc_rdy,
    input  logic               mux_done,
    input  lfsrc_e             mux_act,
    output logic [NUM_SRC-1:0] osc_en,
    output logic               mux_go,
    output lfsrc_e             mux_go_src,
    output logic               mux_halt,
    output lfstat_t            stat,
    output logic               started
);
    lfsrc_e sel_q, tgt_q;
    logic   pend_q, glob_q, run_q, go_sent_q;
    logic   keep, turn_off;

    always_comb begin
        keep       = glob_q | (|cons_req);
        turn_off   = sys_off | (run_q & ~keep & ~pend_q);
        mux_halt   = turn_off;
        mux_go     = pend_q & ~go_sent_q & osc_rdy[tgt_q] & ~sys_off;
        mux_go_src = tgt_q;
        osc_en     = '0;
        if (!sys_off) begin
            if (run_q)  osc_en = osc_en | src_onehot(mux_act);
            if (pend_q) osc_en = osc_en | src_onehot(tgt_q);
        end
        stat.running = run_q;
        stat.src     = mux_act;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q     <= SRC_RC;
            tgt_q     <= SRC_RC;
            pend_q    <= 1'b0;
            glob_q    <= 1'b0;
            run_q     <= 1'b0;
            go_sent_q <= 1'b0;
            started   <= 1'b0;
        end else if (sys_off) begin
            pend_q    <= 1'b0;
            glob_q    <= 1'b0;
            run_q     <= 1'b0;
            go_sent_q <= 1'b0;
            started   <= 1'b0;
        end else begin
            started <= 1'b0;
            if (sel_wr) sel_q <= sel_data;
            if (start_task && !go_sent_q) begin
                glob_q <= 1'b1;
                tgt_q  <= sel_q;
                pend_q <= 1'b1;
            end else if (stop_task && run_q) begin
                glob_q <= 1'b0;
            end
            if (mux_go) go_sent_q <= 1'b1;
            if (mux_done) begin
                pend_q    <= 1'b0;
                go_sent_q <= 1'b0;
                run_q     <= 1'b1;
                started   <= 1'b1;
            end else if (turn_off) begin
                run_q <= 1'b0;
            end
        end
    end

    // R2: the started event coincides with the running state
    a_r2_started_with_run: assert property (@(posedge clk) disable iff (rst)
        started |-> run_q);

    // R6: a consumer request keeps a running clock alive
    a_r6_consumer_holds: assert property (@(posedge clk) disable iff (rst)
        (run_q && (|cons_req) && !sys_off) |=> run_q);

    // R7: a stop before running leaves the software request untouched
    a_r7_early_stop_ignored: assert property (@(posedge clk) disable iff (rst)
        (stop_task && !run_q && !sys_off && !start_task) |=> (glob_q == $past(glob_q)));

    // R8: system-off clears the running state and any event
    a_r8_sysoff_kills: assert property (@(posedge clk) disable iff (rst)
        sys_off |=> (!run_q && !started && !pend_q));

endmodule

// File: rtl/lfclk_switcher.sv
module lfclk_switcher
    import lfclk_pkg::*;
#(
    parameter int N_CONS       = 2,
    parameter int RC_START_CYC = 20000,
    parameter int XO_START_CYC = 15000000,
    parameter int RC_HALF_CYC  = 8,
    parameter int XO_HALF_CYC  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sys_off,
    input  logic              src_wr,
    input  logic              src_wdata,
    input  logic              start_task,
    input  logic              stop_task,
    input  logic [N_CONS-1:0] cons_req,
    output logic              lf_clk,
    output logic              started_evt,
    output logic              stat_running,
    output logic              stat_src
);
    logic [NUM_SRC-1:0] osc_en, osc_rdy, osc_lvl;
    logic               mux_go, mux_halt, mux_done;
    lfsrc_e             mux_go_src, mux_act, sel_data;
    lfstat_t            stat;

    assign sel_data = lfsrc_e'(src_wdata);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_osc
        localparam int ST = (i == int'(SRC_RC)) ? RC_START_CYC : XO_START_CYC;
        localparam int HC = (i == int'(SRC_RC)) ? RC_HALF_CYC  : XO_HALF_CYC;
        lfclk_osc_model #(.START_CYC(ST), .HALF_CYC(HC)) i_osc (
            .clk (clk),
            .rst (rst),
            .en  (osc_en[i]),
            .rdy (osc_rdy[i]),
            .lvl (osc_lvl[i])
        );
    end

    lfclk_ctrl #(.N_CONS(N_CONS)) i_ctrl (
        .clk        (clk),
        .rst        (rst),
        .sys_off    (sys_off),
        .sel_wr     (src_wr),
        .sel_data   (sel_data),
        .start_task (start_task),
        .stop_task  (stop_task),
        .cons_req   (cons_req),
        .osc_rdy    (osc_rdy),
        .mux_done   (mux_done),
        .mux_act    (mux_act),
        .osc_en     (osc_en),
        .mux_go     (mux_go),
        .mux_go_src (mux_go_src),
        .mux_halt   (mux_halt),
        .stat       (stat),
        .started    (started_evt)
    );

    lfclk_glitchless_mux #(.NSRC(NUM_SRC)) i_mux (
        .clk    (clk),
        .rst    (rst),
        .lvl    (osc_lvl),
        .go     (mux_go),
        .go_src (mux_go_src),
        .halt   (mux_halt),
        .out_q  (lf_clk),
        .act    (mux_act),
        .done   (mux_done)
    );

    assign stat_running = stat.running;
    assign stat_src     = stat.src;

    // R5: the output is low whenever the clock is not running
    a_r5_low_when_off: assert property (@(posedge clk) disable iff (rst)
        (!stat_running && !$past(stat_running)) |-> !lf_clk);

endmodule

// File: tb/test_lfclk_switcher.sv
module test_lfclk_switcher;
    localparam int RC_ST = 20, XO_ST = 50, RC_H = 3, XO_H = 5;

    logic       clk = 1'b0, rst = 1'b1;
    logic       sys_off = 1'b0, src_wr = 1'b0, src_wdata = 1'b0;
    logic       start_task = 1'b0, stop_task = 1'b0;
    logic [1:0] cons_req = 2'b00;
    logic       lf_clk, started_evt, stat_running, stat_src;

    int n_chk = 0, n_fail = 0;
    int rises = 0, starts = 0, bad_hi = 0, good_hi = 0, hi_len = 0;
    logic prev_out = 1'b0;

    always #2.5 clk = ~clk;

    lfclk_switcher #(.N_CONS(2), .RC_START_CYC(RC_ST), .XO_START_CYC(XO_ST),
                     .RC_HALF_CYC(RC_H), .XO_HALF_CYC(XO_H)) i_lfclk_switcher (
        .clk(clk), .rst(rst), .sys_off(sys_off), .src_wr(src_wr), .src_wdata(src_wdata),
        .start_task(start_task), .stop_task(stop_task), .cons_req(cons_req),
        .lf_clk(lf_clk), .started_evt(started_evt), .stat_running(stat_running),
        .stat_src(stat_src));

    // pulse monitor: high pulses that end while running must be one half period
    always @(negedge clk) begin
        if (!rst) begin
            if (started_evt) starts++;
            if (lf_clk && !prev_out) rises++;
            if (lf_clk) hi_len++;
            else if (prev_out) begin
                if (stat_running) begin
                    if (hi_len == RC_H || hi_len == XO_H) good_hi++;
                    else bad_hi++;
                end
                hi_len = 0;
            end
            prev_out = lf_clk;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_start();
        start_task = 1'b1; cyc(1); start_task = 1'b0;
    endtask

    task automatic pulse_stop();
        stop_task = 1'b1; cyc(1); stop_task = 1'b0;
    endtask

    task automatic write_sel(input logic v);
        src_wr = 1'b1; src_wdata = v; cyc(1); src_wr = 1'b0;
    endtask

    task automatic wait_started(input int limit, output int waited);
        int s0 = starts;
        waited = 0;
        while (starts == s0 && waited < limit) begin cyc(1); waited++; end
    endtask

    // measure the length of the next complete high pulse
    task automatic next_hi(output int len);
        len = 0;
        while (lf_clk) cyc(1);
        while (!lf_clk) cyc(1);
        while (lf_clk) begin cyc(1); len++; end
    endtask

    initial begin
        repeat (300000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int w, r0, len;
        cyc(3); rst = 1'b0; cyc(2);
        // reset state
        check(!lf_clk && !stat_running && !started_evt, "R2 reset idle", int'(lf_clk), 0);
        check(stat_src == 1'b0, "R1 reset src", int'(stat_src), 0);

        // R1/R2/R9: cold start with the default source
        pulse_start();
        wait_started(200, w);
        check(w >= RC_ST && w <= RC_ST + 30, "R9 rc start time", w, RC_ST);
        check(stat_running == 1'b1, "R2 running", int'(stat_running), 1);
        check(stat_src == 1'b0, "R1 default rc", int'(stat_src), 0);
        next_hi(len);
        check(len == RC_H, "R2 rc half period", len, RC_H);

        // R3: live change to crystal, old source keeps the output alive
        write_sel(1'b1);
        r0 = rises;
        pulse_start();
        w = 1;
        for (int i = 0; i < 40; i++) begin
            cyc(1); w++;
            if (stat_src != 1'b0 || starts != 0 && started_evt) break;
        end
        check(stat_src == 1'b0, "R3 old src kept", int'(stat_src), 0);
        check(rises - r0 >= 5, "R3 output alive", rises - r0, 5);
        begin
            int w2;
            wait_started(200, w2);
            w += w2;
        end
        check(w >= XO_ST, "R9 xo start time", w, XO_ST);
        check(stat_src == 1'b1, "R3 new src", int'(stat_src), 1);
        next_hi(len);
        check(len == XO_H, "R3 xo half period", len, XO_H);

        // R10: restart the active source
        pulse_start();
        wait_started(200, w);
        check(w <= 4 * XO_H + 8, "R10 quick restart", w, 4 * XO_H + 8);
        check(stat_src == 1'b1, "R10 src unchanged", int'(stat_src), 1);

        // R3: change back to rc
        write_sel(1'b0);
        pulse_start();
        wait_started(200, w);
        check(stat_src == 1'b0 && w >= RC_ST, "R3 back to rc", int'(stat_src), 0);
        next_hi(len);
        check(len == RC_H, "R3 rc after return", len, RC_H);

        // R6: consumer holds the clock through a stop
        cons_req = 2'b10;
        pulse_stop();
        r0 = rises;
        cyc(30);
        check(stat_running == 1'b1, "R6 held running", int'(stat_running), 1);
        check(rises - r0 >= 3, "R6 still toggling", rises - r0, 3);

        // R5: dropping the consumer stops the clock
        cons_req = 2'b00;
        cyc(2);
        check(stat_running == 1'b0, "R5 stopped", int'(stat_running), 0);
        r0 = rises;
        cyc(20);
        check(rises == r0 && !lf_clk, "R5 output quiet", rises - r0, 0);

        // R7: stop before running is ignored
        pulse_start();
        pulse_stop();
        wait_started(200, w);
        check(w < 200, "R7 start completes", w, RC_ST);
        cyc(30);
        check(stat_running == 1'b1, "R7 still running", int'(stat_running), 1);
        pulse_stop();
        cyc(2);
        check(stat_running == 1'b0, "R5 stop honoured", int'(stat_running), 0);

        // R8: system-off forces off and blocks tasks
        pulse_start();
        wait_started(200, w);
        sys_off = 1'b1;
        cyc(2);
        check(!stat_running && !lf_clk, "R8 forced off", int'(stat_running), 0);
        pulse_start();
        cyc(2);
        sys_off = 1'b0;
        r0 = starts;
        cyc(80);
        check(!stat_running && starts == r0, "R8 start ignored", int'(stat_running), 0);
        check(rises >= 0 && !lf_clk, "R8 output low", int'(lf_clk), 0);

        // R4: every running high pulse had a legal length
        check(bad_hi == 0, "R4 no short pulse", bad_hi, 0);
        check(good_hi >= 10, "R4 pulses observed", good_hi, 10);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule